// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block sits on the host side of a serial analog-to-digital converter and runs every exchange with it. A local requester hands over one command at a time: an 8-bit mode/address word, a flag that chooses a programming frame or a read-only frame, and the output word length that a programming frame sets. The sequencer lowers chip-select and generates a divided serial clock. It shifts the command out most-significant bit first and shifts in the result of the previous conversion. It then closes the frame and returns that result, right-aligned, with a one-cycle valid strobe.

The number of clock pulses in a frame always equals the converter's current output word length. That length is 13 after reset and is updated after each programming frame that carries a legal length. A busy flag is raised by every programming frame, because such a frame starts a conversion, and is cleared by the end-of-conversion input. While the flag is set, new frames are held off unless the requester asks for an abort, and an aborted frame's result is flagged invalid. A power-down request is passed to the converter, and no frame starts until a parameterised wake-up time has elapsed after release. The converter's data-ready output is checked at the end of each frame to confirm that both sides agree on the frame length.

Top module: `sadc_host`

## Requirements
- R1: During and right after reset, chip-select is high, the serial clock is low, the conversion-mode pin is high, `res_valid` is low and `req_ready` is low.
- R2: After reset a frame is 13 serial-clock pulses. Every frame has exactly as many rising edges as the stored frame length.
- R3: In a programming frame (`req_prog`=1) the mode pin is low, and `req_cmd` is driven on the data line most-significant bit first, one bit per pulse, with zeros after the command's 8 bits. In a read-only frame the mode pin is high and the data line stays 0. The data line never changes while the serial clock is high, and the mode pin is high whenever chip-select is high.
- R4: Each result bit is sampled just before a rising serial-clock edge, the first one after chip-select falls. The bits enter most-significant first and are right-aligned in `res_data`, with zeros above the frame length. `res_valid` is a single-cycle pulse in the cycle in which chip-select returns high.
- R5: A programming frame whose `req_len` lies in 1..13 sets the frame length used from the next frame on. A value of 0 or above 13 leaves the length unchanged, and read-only frames never change it.
- R6: Chip-select falls only while the serial clock is low, the serial clock stays low while chip-select is high, and chip-select stays high for at least 2*`CLK_DIV` system cycles between frames.
- R7: `adc_pd` follows `pwr_down_req` one cycle later. No frame starts while it is high, nor within `PWRUP_CYCLES` cycles after it falls or after reset, and `req_ready` stays low over that time.
- R8: After a programming frame `req_ready` stays low until `adc_eoc` is seen high. A read-only frame leaves it high.
- R9: With `req_abort` high, a frame starts even while busy, and its result is returned with `res_invalid`=1. Other frames return `res_invalid`=0.
- R10: `res_dor_err` is 1 when `adc_dor` is low half a serial-clock period after the last falling edge of a frame, and 0 otherwise.
- R11: Each serial-clock half period, and the time from chip-select falling to the first rising edge, lasts exactly `CLK_DIV` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request to run one frame |
| req_ready | output | 1 | A frame can be accepted this cycle |
| req_prog | input | 1 | 1: programming frame, 0: read-only frame |
| req_cmd | input | CMD_W | Mode/address word, sent MSB first |
| req_len | input | LEN_W | New output word length set by a programming frame |
| req_abort | input | 1 | Start even while a conversion is running |
| pwr_down_req | input | 1 | Power the converter down while high |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_di | output | 1 | Serial command data to the converter |
| adc_conv | output | 1 | Mode pin: low programs, high reads only |
| adc_pd | output | 1 | Power-down to the converter |
| adc_do | input | 1 | Serial result data from the converter |
| adc_dor | input | 1 | Converter data-ready, high once all bits are out |
| adc_eoc | input | 1 | End of conversion from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Right-aligned result |
| res_invalid | output | 1 | Result came from an aborted conversion |
| res_dor_err | output | 1 | Data-ready disagreed with the frame length |

## Verification
A stored frame length that is off by one shows up on the very next frame: the number of clock pulses changes, the result is shifted by one position, and data-ready reports a mismatch at frame end. A busy flag or power-up counter in the wrong state shows at once as a `req_ready` level that is wrong in the cycles after a frame or after power-down is released. The bench applies each command against a behavioural converter and checks, per frame, the pulse count, the command bits the converter saw, the mode-pin level, the returned data and the two flags.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2,
      ST_GAP   = 2'd3
   } fr_state_e;

   localparam int unsigned POWERON_FRAME_LEN = 13;

endpackage

// File: rtl/sadc_half_tick.sv
`timescale 1ns/1ps
module sadc_half_tick #(
   parameter int unsigned CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   generate
      if (CLK_DIV == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            cnt_q <= '0;
            else if (!en)                          cnt_q <= '0;
            else if (cnt_q == CNT_W'(CLK_DIV - 1)) cnt_q <= '0;
            else                                   cnt_q <= cnt_q + 1'b1;
         end
         assign tick = en && (cnt_q == CNT_W'(CLK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/sadc_pwr_gate.sv
`timescale 1ns/1ps
module sadc_pwr_gate #(
   parameter int unsigned PWRUP_CYCLES = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_down_req,
   output logic pd,
   output logic pwr_ok
);
   localparam int unsigned CNT_W = (PWRUP_CYCLES > 0) ? $clog2(PWRUP_CYCLES + 1) : 1;

   logic pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pd_q <= 1'b0;
      else        pd_q <= pwr_down_req;
   end
   assign pd = pd_q;

   generate
      if (PWRUP_CYCLES == 0) begin : g_nowait
         assign pwr_ok = !pd_q && !pwr_down_req;
      end else begin : g_wait
         logic [CNT_W-1:0] wait_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            wait_q <= CNT_W'(PWRUP_CYCLES);
            else if (pd_q)         wait_q <= CNT_W'(PWRUP_CYCLES);
            else if (wait_q != '0) wait_q <= wait_q - 1'b1;
         end
         assign pwr_ok = !pd_q && !pwr_down_req && (wait_q == '0);
      end
   endgenerate
endmodule

// File: rtl/sadc_busy_track.sv
`timescale 1ns/1ps
module sadc_busy_track (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic abort_i,
   input  logic eoc_i,
   output logic busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy <= 1'b0;
      else if (set_i)            busy <= 1'b1;
      else if (abort_i || eoc_i) busy <= 1'b0;
   end
endmodule

// File: rtl/sadc_frame_seq.sv
`timescale 1ns/1ps
module sadc_frame_seq
   import sadc_pkg::*;
#(
   parameter int unsigned CMD_W   = 8,
   parameter int unsigned RES_W   = 13,
   parameter int unsigned LEN_W   = 4,
   parameter int unsigned DEF_LEN = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_prog,
   input  logic [CMD_W-1:0] start_cmd,
   input  logic [LEN_W-1:0] start_len,
   input  logic             start_abort,
   input  logic             half_tick,
   input  logic             adc_do,
   input  logic             adc_dor,
   output logic             idle,
   output logic             active,
   output logic             done_prog,
   output logic             cs_n,
   output logic             sclk,
   output logic             di,
   output logic             conv,
   output logic             res_valid,
   output logic [RES_W-1:0] res_data,
   output logic             res_invalid,
   output logic             res_dor_err
);
   fr_state_e        st_q;
   logic [LEN_W-1:0] frame_len_q, bit_idx_q, pend_len_q;
   logic [CMD_W-1:0] cmd_sr_q;
   logic [RES_W-1:0] res_sr_q;
   logic             pend_prog_q, pend_ok_q, abort_q, gap_q;
   logic             last_bit;

   assign idle      = (st_q == ST_IDLE);
   assign active    = !idle;
   assign last_bit  = (bit_idx_q == frame_len_q - 1'b1);
   assign done_prog = (st_q == ST_TAIL) && half_tick && pend_prog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cs_n        <= 1'b1;
         sclk        <= 1'b0;
         di          <= 1'b0;
         conv        <= 1'b1;
         frame_len_q <= LEN_W'(DEF_LEN);
         bit_idx_q   <= '0;
         pend_len_q  <= '0;
         cmd_sr_q    <= '0;
         res_sr_q    <= '0;
         pend_prog_q <= 1'b0;
         pend_ok_q   <= 1'b0;
         abort_q     <= 1'b0;
         gap_q       <= 1'b0;
         res_valid   <= 1'b0;
         res_data    <= '0;
         res_invalid <= 1'b0;
         res_dor_err <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  cs_n        <= 1'b0;
                  conv        <= !start_prog;
                  di          <= start_prog && start_cmd[CMD_W-1];
                  cmd_sr_q    <= start_cmd << 1;
                  res_sr_q    <= '0;
                  bit_idx_q   <= '0;
                  pend_prog_q <= start_prog;
                  pend_len_q  <= start_len;
                  pend_ok_q   <= (start_len != '0) && (start_len <= LEN_W'(RES_W));
                  abort_q     <= start_abort;
                  st_q        <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (half_tick) begin
                  if (!sclk) begin
                     res_sr_q <= {res_sr_q[RES_W-2:0], adc_do};
                     sclk     <= 1'b1;
                  end else begin
                     sclk <= 1'b0;
                     if (last_bit) begin
                        st_q <= ST_TAIL;
                     end else begin
                        bit_idx_q <= bit_idx_q + 1'b1;
                        di        <= pend_prog_q && cmd_sr_q[CMD_W-1];
                        cmd_sr_q  <= cmd_sr_q << 1;
                     end
                  end
               end
            end
            ST_TAIL: begin
               if (half_tick) begin
                  cs_n        <= 1'b1;
                  conv        <= 1'b1;
                  di          <= 1'b0;
                  res_valid   <= 1'b1;
                  res_data    <= res_sr_q;
                  res_invalid <= abort_q;
                  res_dor_err <= !adc_dor;
                  if (pend_prog_q && pend_ok_q) frame_len_q <= pend_len_q;
                  gap_q       <= 1'b0;
                  st_q        <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (half_tick) begin
                  if (gap_q) st_q  <= ST_IDLE;
                  else       gap_q <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sadc_host.sv
`timescale 1ns/1ps
module sadc_host
   import sadc_pkg::*;
#(
   parameter  int unsigned CLK_DIV      = 4,
   parameter  int unsigned PWRUP_CYCLES = 50000,
   parameter  int unsigned CMD_W        = 8,
   parameter  int unsigned RES_W        = 13,
   parameter  int unsigned DEF_LEN      = POWERON_FRAME_LEN,
   localparam int unsigned LEN_W        = $clog2(RES_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_prog,
   input  logic [CMD_W-1:0] req_cmd,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_abort,
   input  logic             pwr_down_req,
   output logic             adc_cs_n,
   output logic             adc_sclk,
   output logic             adc_di,
   output logic             adc_conv,
   output logic             adc_pd,
   input  logic             adc_do,
   input  logic             adc_dor,
   input  logic             adc_eoc,
   output logic             res_valid,
   output logic [RES_W-1:0] res_data,
   output logic             res_invalid,
   output logic             res_dor_err
);
   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (CMD_W < 1) begin : g_bad_cmd
         $error("CMD_W must be at least 1");
      end
      if (RES_W < 2) begin : g_bad_res
         $error("RES_W must be at least 2");
      end
      if (DEF_LEN < 1 || DEF_LEN > RES_W) begin : g_bad_len
         $error("DEF_LEN must lie in 1..RES_W");
      end
   endgenerate

   logic seq_idle, seq_active, half_tick, pwr_ok, busy, start, done_prog;

   assign req_ready = seq_idle && pwr_ok && (!busy || req_abort);
   assign start     = req_valid && req_ready;

   sadc_half_tick #(.CLK_DIV(CLK_DIV)) tick_i (
      .clk (clk), .rst_n (rst_n), .en (seq_active), .tick (half_tick)
   );

   sadc_pwr_gate #(.PWRUP_CYCLES(PWRUP_CYCLES)) pwr_i (
      .clk (clk), .rst_n (rst_n), .pwr_down_req (pwr_down_req),
      .pd (adc_pd), .pwr_ok (pwr_ok)
   );

   sadc_busy_track busy_i (
      .clk (clk), .rst_n (rst_n), .set_i (done_prog),
      .abort_i (start && busy), .eoc_i (adc_eoc), .busy (busy)
   );

   sadc_frame_seq #(
      .CMD_W (CMD_W), .RES_W (RES_W), .LEN_W (LEN_W), .DEF_LEN (DEF_LEN)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_prog  (req_prog),
      .start_cmd   (req_cmd),
      .start_len   (req_len),
      .start_abort (busy),
      .half_tick   (half_tick),
      .adc_do      (adc_do),
      .adc_dor     (adc_dor),
      .idle        (seq_idle),
      .active      (seq_active),
      .done_prog   (done_prog),
      .cs_n        (adc_cs_n),
      .sclk        (adc_sclk),
      .di          (adc_di),
      .conv        (adc_conv),
      .res_valid   (res_valid),
      .res_data    (res_data),
      .res_invalid (res_invalid),
      .res_dor_err (res_dor_err)
   );
endmodule

// File: rtl/sadc_host_chk.sv
`timescale 1ns/1ps
module sadc_host_chk #(
   parameter int unsigned PWRUP_CYCLES = 50000
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic adc_cs_n,
   input logic adc_sclk,
   input logic adc_di,
   input logic adc_conv,
   input logic adc_pd,
   input logic res_valid
);
   int unsigned pwr_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    pwr_run <= 0;
      else if (adc_pd)               pwr_run <= 0;
      else if (pwr_run < PWRUP_CYCLES) pwr_run <= pwr_run + 1;
   end

   AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n |-> !adc_sclk); // R6
   AST_CS_FALL_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n) |-> (!adc_sclk && !$past(adc_sclk))); // R6
   AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> adc_cs_n); // R6
   AST_DI_HELD_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      adc_sclk |-> $stable(adc_di)); // R3
   AST_CONV_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cs_n |-> adc_conv); // R3
   AST_PWRUP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n) |-> (!adc_pd && pwr_run >= PWRUP_CYCLES)); // R7
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid); // R4
   AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $rose(adc_cs_n)); // R4
endmodule

bind sadc_host sadc_host_chk #(.PWRUP_CYCLES(PWRUP_CYCLES)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .adc_cs_n  (adc_cs_n),
   .adc_sclk  (adc_sclk),
   .adc_di    (adc_di),
   .adc_conv  (adc_conv),
   .adc_pd    (adc_pd),
   .res_valid (res_valid)
);

// File: tb/sadc_host_tb_top.sv
`timescale 1ns/1ps
module sadc_host_tb_top;
   localparam int CLK_DIV = 2;
   localparam int PWRUP   = 400;

   typedef struct packed {
      logic        prog;
      logic [7:0]  cmd;
      logic [3:0]  len;
      logic [12:0] word;
      logic [3:0]  flen;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'hA5, 4'd13, 13'h1ABC, 4'd13},
      '{1'b0, 8'hFF, 4'd8,  13'h0F0F, 4'd13},
      '{1'b1, 8'h3C, 4'd8,  13'h1234, 4'd13},
      '{1'b1, 8'hC3, 4'd12, 13'h1F5A, 4'd8 },
      '{1'b0, 8'h00, 4'd5,  13'h1ABC, 4'd12},
      '{1'b1, 8'h81, 4'd0,  13'h0123, 4'd12},
      '{1'b1, 8'h7E, 4'd14, 13'h1FFF, 4'd12},
      '{1'b1, 8'hE7, 4'd13, 13'h0456, 4'd12},
      '{1'b0, 8'h00, 4'd3,  13'h1555, 4'd13}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_prog = 1'b0, req_abort = 1'b0;
   logic [7:0]  req_cmd = '0;
   logic [3:0]  req_len = '0;
   logic        pwr_down_req = 1'b0;
   logic        req_ready, adc_cs_n, adc_sclk, adc_di, adc_conv, adc_pd;
   logic        adc_do = 1'b0, adc_dor = 1'b1, adc_eoc = 1'b0;
   logic        res_valid, res_invalid, res_dor_err;
   logic [12:0] res_data;

   always #2.5 clk = ~clk;

   sadc_host #(.CLK_DIV(CLK_DIV), .PWRUP_CYCLES(PWRUP)) dut_i (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_prog (req_prog),
      .req_cmd (req_cmd), .req_len (req_len), .req_abort (req_abort),
      .pwr_down_req (pwr_down_req),
      .adc_cs_n (adc_cs_n), .adc_sclk (adc_sclk), .adc_di (adc_di),
      .adc_conv (adc_conv), .adc_pd (adc_pd),
      .adc_do (adc_do), .adc_dor (adc_dor), .adc_eoc (adc_eoc),
      .res_valid (res_valid), .res_data (res_data),
      .res_invalid (res_invalid), .res_dor_err (res_dor_err)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // behavioural converter
   logic [15:0] m_word = '0;
   int          m_len = 13, m_idx = 0, m_falls = 0, rise_cnt = 0;
   logic [15:0] di_cap = '0;

   always @(negedge adc_cs_n) begin
      m_idx = m_len - 1;
      m_falls = 0;
      rise_cnt = 0;
      di_cap = '0;
      adc_dor = 1'b0;
      adc_do = m_word[m_idx];
   end

   always @(negedge adc_sclk) begin
      if (adc_cs_n === 1'b0) begin
         m_falls++;
         m_idx--;
         adc_do = (m_idx >= 0) ? m_word[m_idx] : 1'b0;
         if (m_falls >= m_len) adc_dor = 1'b1;
      end
   end

   always @(posedge adc_sclk) begin
      if (adc_cs_n === 1'b0) begin
         di_cap = {di_cap[14:0], adc_di};
         rise_cnt++;
      end
   end

   // timing monitors, sampled away from the active edge
   int   run = 0, hp_bad = 0, gap_run = 0, last_gap = 0;
   logic sc_p = 1'b0, cs_p = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if ((adc_sclk != sc_p) || (!adc_cs_n && cs_p)) begin
            if (adc_sclk != sc_p && run != CLK_DIV) hp_bad++;
            run = 1;
         end else begin
            run++;
         end
         if (adc_cs_n) gap_run++;
         else if (cs_p) begin
            last_gap = gap_run;
            gap_run = 0;
         end
         sc_p = adc_sclk;
         cs_p = adc_cs_n;
      end
   end

   task automatic run_frame(input bit prog, input bit [7:0] cmd, input bit [3:0] len,
                            input bit abort, input bit [15:0] word, input int mlen,
                            input bit do_eoc,
                            output bit [12:0] data, output bit inv, output bit derr,
                            output bit conv_seen);
      int guard;
      m_word = word;
      m_len  = mlen;
      @(negedge clk);
      req_abort = abort;
      guard = 0;
      while (!req_ready && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk(req_ready == 1'b1, "R8 ready before frame", 32'(req_ready), 32'd1);
      req_valid = 1'b1;
      req_prog  = prog;
      req_cmd   = cmd;
      req_len   = len;
      @(negedge clk);
      req_valid = 1'b0;
      req_abort = 1'b0;
      conv_seen = adc_conv;
      guard = 0;
      while (!res_valid && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      data = res_data;
      inv  = res_invalid;
      derr = res_dor_err;
      if (do_eoc) begin
         @(negedge clk);
         adc_eoc = 1'b1;
         @(negedge clk);
         adc_eoc = 1'b0;
      end
   endtask

   function automatic logic [15:0] exp_di(input bit prog, input bit [7:0] cmd, input int fl);
      if (!prog) return 16'h0;
      if (fl >= 8) return 16'(cmd) << (fl - 8);
      return 16'(cmd) >> (8 - fl);
   endfunction

   initial begin
      bit [12:0] d;
      bit        inv, derr, cv;
      logic [12:0] mask;

      repeat (3) @(negedge clk);
      chk(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R1 cs/sclk in reset", {30'd0, adc_cs_n, adc_sclk}, 32'h2);
      chk(adc_conv == 1'b1 && res_valid == 1'b0, "R1 conv/valid in reset", {30'd0, adc_conv, res_valid}, 32'h2);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b0, "R1 ready low after reset", 32'(req_ready), 32'd0);
      chk(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R1 idle pins after reset", {30'd0, adc_cs_n, adc_sclk}, 32'h2);
      repeat (PWRUP / 2) @(negedge clk);
      chk(req_ready == 1'b0, "R7 wait after reset", 32'(req_ready), 32'd0);
      repeat (PWRUP / 2 + 4) @(negedge clk);
      chk(req_ready == 1'b1, "R7 ready after wait", 32'(req_ready), 32'd1);

      // vector table
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VECS[i];
         mask = 13'((16'd1 << v.flen) - 1);
         run_frame(v.prog, v.cmd, v.len, 1'b0, {3'b0, v.word}, int'(v.flen), v.prog, d, inv, derr, cv);
         chk(d == (v.word & mask), $sformatf("R4 data row %0d", i), 32'(d), 32'(v.word & mask));
         chk(rise_cnt == int'(v.flen), $sformatf("R2 R5 pulses row %0d", i), 32'(rise_cnt), 32'(v.flen));
         chk(di_cap == exp_di(v.prog, v.cmd, int'(v.flen)), $sformatf("R3 di row %0d", i),
             32'(di_cap), 32'(exp_di(v.prog, v.cmd, int'(v.flen))));
         chk(cv == !v.prog, $sformatf("R3 conv row %0d", i), 32'(cv), 32'(!v.prog));
         chk(inv == 1'b0, $sformatf("R9 no invalid row %0d", i), 32'(inv), 32'd0);
         chk(derr == 1'b0, $sformatf("R10 no dor err row %0d", i), 32'(derr), 32'd0);
         if (i > 0) chk(last_gap >= 2 * CLK_DIV, $sformatf("R6 gap row %0d", i), 32'(last_gap), 32'(2 * CLK_DIV));
      end

      // busy and abort
      run_frame(1'b1, 8'h42, 4'd13, 1'b0, 16'h0AAA, 13, 1'b0, d, inv, derr, cv);
      chk(d == 13'h0AAA, "R4 data busy frame", 32'(d), 32'h0AAA);
      repeat (20) @(negedge clk);
      chk(req_ready == 1'b0, "R8 held while busy", 32'(req_ready), 32'd0);
      run_frame(1'b1, 8'h99, 4'd13, 1'b1, 16'h0321, 13, 1'b1, d, inv, derr, cv);
      chk(inv == 1'b1, "R9 aborted frame invalid", 32'(inv), 32'd1);
      chk(d == 13'h0321, "R9 aborted frame data", 32'(d), 32'h0321);
      repeat (20) @(negedge clk);
      chk(req_ready == 1'b1, "R8 ready after eoc", 32'(req_ready), 32'd1);
      run_frame(1'b0, 8'h00, 4'd0, 1'b0, 16'h1001, 13, 1'b0, d, inv, derr, cv);
      chk(inv == 1'b0, "R9 normal frame valid", 32'(inv), 32'd0);
      repeat (20) @(negedge clk);
      chk(req_ready == 1'b1, "R8 read-only leaves ready", 32'(req_ready), 32'd1);

      // data-ready mismatch: converter expects 15 bits
      run_frame(1'b0, 8'h00, 4'd0, 1'b0, 16'h7FFF, 15, 1'b0, d, inv, derr, cv);
      chk(derr == 1'b1, "R10 dor mismatch flagged", 32'(derr), 32'd1);
      chk(rise_cnt == 13, "R5 length kept", 32'(rise_cnt), 32'd13);

      // power down
      @(negedge clk);
      pwr_down_req = 1'b1;
      @(negedge clk);
      chk(adc_pd == 1'b1, "R7 pd follows request", 32'(adc_pd), 32'd1);
      chk(req_ready == 1'b0, "R7 no ready while down", 32'(req_ready), 32'd0);
      repeat (10) @(negedge clk);
      pwr_down_req = 1'b0;
      @(negedge clk);
      chk(adc_pd == 1'b0, "R7 pd released", 32'(adc_pd), 32'd0);
      repeat (PWRUP / 2) @(negedge clk);
      chk(req_ready == 1'b0, "R7 wait after release", 32'(req_ready), 32'd0);
      repeat (PWRUP / 2 + 6) @(negedge clk);
      chk(req_ready == 1'b1, "R7 ready after release", 32'(req_ready), 32'd1);
      run_frame(1'b0, 8'h00, 4'd0, 1'b0, 16'h0B0B, 13, 1'b0, d, inv, derr, cv);
      chk(d == 13'h0B0B, "R4 data after power-up", 32'(d), 32'h0B0B);

      chk(hp_bad == 0, "R11 half period", 32'(hp_bad), 32'd0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #750000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule